// File: doc/BRIEF.md
# Crossing Trigger Decision Unit

This block decides, once per bunch crossing, whether the readout system takes an event. Every clock cycle is one crossing. An internal bunch counter labels it. The counter restarts on an orbit pulse and wraps at the end of the orbit. For the crossing, the block combines four inputs:

- the aligned low-level trigger decision;
- an optional calibration or periodic trigger request with its type code;
- a one-bit veto looked up in a per-crossing filling-scheme table;
- the throttle lines of the back-end crates.

The result is a record carrying accept or reject, the crossing ID, the trigger kind, the calibration code and the veto and header-only flags. It leaves the block after a fixed number of clocks.

A throttled system converts every would-be accept into a reject, and each new throttle is reported together with the crossing ID at which it appeared. A non-zero-suppressed readout forces a programmable number of following crossings to header-only so that front-end buffers can drain.

A small state machine with two states runs the drain window:
- ST_RUN is normal operation.
- ST_DRAIN is the forced header-only window.
- The transition RUN to DRAIN fires on an accepted NZS crossing when the gap setting is nonzero.
- The transition DRAIN to RUN fires on the last crossing of the window.

Two saturating counters record the dead time caused by throttle and by veto.

Top module: `trig_decision_unit`

## Requirements
- R1: While reset is low, dec_valid, thr_rpt_valid and both dead-time counters are 0. Reset clears every filling-scheme table entry to "not vetoed". The first crossing after reset release has ID 0.
- R2: Every clock is one crossing. The crossing ID counts up by one per clock and wraps from NUM_BX-1 to 0. When orbit_sync is high during a crossing, the next crossing has ID 0. A crossing's record appears on the dec_* outputs after exactly LATENCY rising edges, counting the edge that ends the crossing, with dec_valid=1 and dec_bxid equal to that crossing's ID.
- R3: dec_kind is encoded as 0 = none, 1 = low-level trigger, 2 = calibration. With only llt_yes high the result is kind 1 and accept. With cal_req high, the kind is 2 and dec_cal_code carries cal_code, even if llt_yes is also high. With no request the result is kind 0 and reject. dec_cal_code is 0 for kinds other than 2.
- R4: If any throttle_in bit is high during a crossing, that crossing is rejected, and its kind and code are still reported.
- R5: On the clock after a crossing in which a throttle_in bit goes from low to high, thr_rpt_valid is 1. In that cycle thr_rpt_mask holds exactly the bits that rose and thr_rpt_bxid holds that crossing's ID. A bit that stays high produces no further report.
- R6: A write with vt_we=1 stores vt_veto at address vt_addr of the table. A crossing whose table entry is 1 is rejected with dec_veto=1 and dec_header_only=1, whatever its trigger inputs.
- R7: When a crossing is accepted with nzs_req=1 outside a drain window, dec_nzs=1 for it. The next ho_gap crossings then have dec_header_only=1. With ho_gap=0 no window opens. nzs_req during a window neither sets dec_nzs nor extends the window.
- R8: dead_veto_cnt counts crossings with a trigger request and a table veto. dead_thr_cnt counts crossings with a trigger request, no veto and a throttle. When both apply, only dead_veto_cnt increments. Both counters saturate at all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crossing clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| orbit_sync | input | 1 | Next crossing gets ID 0 |
| llt_yes | input | 1 | Low-level trigger decision for this crossing |
| cal_req | input | 1 | Calibration/periodic trigger request |
| cal_code | input | CAL_W | Calibration type code |
| nzs_req | input | 1 | Request non-zero-suppressed readout |
| throttle_in | input | NUM_CRATES | Per-crate throttle (OR of the crate's cards) |
| ho_gap | input | GAP_W | Header-only crossings after an NZS readout |
| vt_we | input | 1 | Filling-scheme table write enable |
| vt_addr | input | BX_W | Table write address (crossing ID) |
| vt_veto | input | 1 | Table write data |
| dec_valid | output | 1 | Decision record valid |
| dec_accept | output | 1 | Crossing accepted |
| dec_bxid | output | BX_W | Crossing ID of the record |
| dec_kind | output | 2 | Trigger kind |
| dec_cal_code | output | CAL_W | Calibration code |
| dec_veto | output | 1 | Crossing vetoed by filling scheme |
| dec_header_only | output | 1 | Header-only readout |
| dec_nzs | output | 1 | Non-zero-suppressed readout |
| thr_rpt_valid | output | 1 | New throttle report |
| thr_rpt_mask | output | NUM_CRATES | Crates whose throttle rose |
| thr_rpt_bxid | output | BX_W | Crossing at which they rose |
| dead_thr_cnt | output | CNT_W | Requests lost to throttle |
| dead_veto_cnt | output | CNT_W | Requests lost to veto |

## Verification
Throttle and veto can hit the same crossing. One stimulus vector pairs a throttled crate with a table entry set for that crossing. It is judged at the output, where the record must show a veto with header-only, and at the counters, which must credit the loss to veto alone. An NZS request can also arrive while a drain window from an earlier NZS readout is still open. The bench places such a request on the first crossing of a window and expects the window to end after its original length, which it confirms by an unforced header flag on the crossing right after.

// File: rtl/tdu_pkg.sv
package tdu_pkg;

    typedef enum logic [1:0] {
        KIND_NONE = 2'd0,
        KIND_PHYS = 2'd1,
        KIND_CAL  = 2'd2
    } trig_kind_e;

    typedef enum logic {
        ST_RUN   = 1'b0,
        ST_DRAIN = 1'b1
    } drain_st_e;

endpackage

// File: rtl/tdu_veto_table.sv
module tdu_veto_table #(
    parameter int NUM_BX = 3564,
    parameter int BX_W   = 12
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [BX_W-1:0] wr_addr,
    input  logic            wr_bit,
    input  logic [BX_W-1:0] rd_addr,
    output logic            rd_bit
);
    localparam logic [BX_W-1:0] LAST_BX = BX_W'(NUM_BX - 1);

    logic mem [NUM_BX];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_BX; i++) begin
                mem[i] <= 1'b0;
            end
        end else if (wr_en && (wr_addr <= LAST_BX)) begin
            mem[wr_addr] <= wr_bit;
        end
    end

    always_comb begin
        rd_bit = (rd_addr <= LAST_BX) ? mem[rd_addr] : 1'b0;
    end

endmodule

// File: rtl/tdu_throttle_mon.sv
module tdu_throttle_mon #(
    parameter int NUM_CRATES = 2,
    parameter int BX_W       = 12
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_CRATES-1:0] thr_in,
    input  logic [BX_W-1:0]       bx_now,
    output logic                  any_thr,
    output logic                  rpt_valid,
    output logic [NUM_CRATES-1:0] rpt_mask,
    output logic [BX_W-1:0]       rpt_bxid
);
    logic [NUM_CRATES-1:0] thr_q;
    logic [NUM_CRATES-1:0] rising;

    always_comb begin
        any_thr = |thr_in;
        rising  = thr_in & ~thr_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            thr_q     <= '0;
            rpt_valid <= 1'b0;
            rpt_mask  <= '0;
            rpt_bxid  <= '0;
        end else begin
            thr_q     <= thr_in;
            rpt_valid <= |rising;
            rpt_mask  <= rising;
            if (|rising) begin
                rpt_bxid <= bx_now;
            end
        end
    end

    AST_RPT_CRATES_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        rpt_valid |-> ((rpt_mask & ~thr_q) == '0)); // R5
    AST_RPT_MASK_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rpt_valid |-> (rpt_mask != '0)); // R5

endmodule

// File: rtl/tdu_drain_fsm.sv
module tdu_drain_fsm
    import tdu_pkg::*;
#(
    parameter int GAP_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             nzs_take,
    input  logic [GAP_W-1:0] gap_cfg,
    output logic             draining
);
    drain_st_e        st_q, st_nx;
    logic [GAP_W-1:0] left_q, left_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= ST_RUN;
            left_q <= '0;
        end else begin
            st_q   <= st_nx;
            left_q <= left_nx;
        end
    end

    always_comb begin
        st_nx   = st_q;
        left_nx = left_q;
        unique case (st_q)
            ST_RUN: begin
                if (nzs_take && (gap_cfg != '0)) begin
                    st_nx   = ST_DRAIN;
                    left_nx = gap_cfg;
                end
            end
            ST_DRAIN: begin
                if (left_q == GAP_W'(1)) begin
                    st_nx   = ST_RUN;
                    left_nx = '0;
                end else begin
                    left_nx = left_q - 1'b1;
                end
            end
        endcase
    end

    always_comb begin
        draining = (st_q == ST_DRAIN);
    end

    AST_DRAIN_COUNT_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_DRAIN) |-> (left_q != '0)); // R7
    AST_NO_NZS_IN_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
        nzs_take |-> (st_q == ST_RUN)); // R7

endmodule

// File: rtl/tdu_delay_line.sv
module tdu_delay_line #(
    parameter int DEPTH = 4,
    parameter int W     = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                stage[i] <= '0;
            end
        end else begin
            stage[0] <= d;
            for (int i = 1; i < DEPTH; i++) begin
                stage[i] <= stage[i-1];
            end
        end
    end

    assign q = stage[DEPTH-1];

endmodule

// File: rtl/trig_decision_unit.sv
module trig_decision_unit
    import tdu_pkg::*;
#(
    parameter int NUM_BX     = 3564,
    parameter int NUM_CRATES = 2,
    parameter int LATENCY    = 4,
    parameter int CAL_W      = 4,
    parameter int GAP_W      = 4,
    parameter int CNT_W      = 16,
    localparam int BX_W      = $clog2(NUM_BX)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  orbit_sync,
    input  logic                  llt_yes,
    input  logic                  cal_req,
    input  logic [CAL_W-1:0]      cal_code,
    input  logic                  nzs_req,
    input  logic [NUM_CRATES-1:0] throttle_in,
    input  logic [GAP_W-1:0]      ho_gap,
    input  logic                  vt_we,
    input  logic [BX_W-1:0]       vt_addr,
    input  logic                  vt_veto,
    output logic                  dec_valid,
    output logic                  dec_accept,
    output logic [BX_W-1:0]       dec_bxid,
    output logic [1:0]            dec_kind,
    output logic [CAL_W-1:0]      dec_cal_code,
    output logic                  dec_veto,
    output logic                  dec_header_only,
    output logic                  dec_nzs,
    output logic                  thr_rpt_valid,
    output logic [NUM_CRATES-1:0] thr_rpt_mask,
    output logic [BX_W-1:0]       thr_rpt_bxid,
    output logic [CNT_W-1:0]      dead_thr_cnt,
    output logic [CNT_W-1:0]      dead_veto_cnt
);
    localparam logic [BX_W-1:0] LAST_BX = BX_W'(NUM_BX - 1);

    typedef struct packed {
        logic             valid;
        logic             accept;
        logic [BX_W-1:0]  bxid;
        trig_kind_e       kind;
        logic [CAL_W-1:0] code;
        logic             veto;
        logic             ho;
        logic             nzs;
    } rec_t;

    localparam int REC_W = $bits(rec_t);

    logic [BX_W-1:0]  bx_cnt;
    logic             veto_now;
    logic             thr_any;
    logic             draining;
    logic             want;
    logic             take;
    logic             nzs_take;
    rec_t             rec_now;
    rec_t             rec_out;
    logic [REC_W-1:0] rec_out_bits;

    // crossing counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bx_cnt <= '0;
        end else if (orbit_sync || (bx_cnt == LAST_BX)) begin
            bx_cnt <= '0;
        end else begin
            bx_cnt <= bx_cnt + 1'b1;
        end
    end

    AST_BX_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        bx_cnt <= LAST_BX); // R2

    tdu_veto_table #(
        .NUM_BX (NUM_BX),
        .BX_W   (BX_W)
    ) u_table (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (vt_we),
        .wr_addr (vt_addr),
        .wr_bit  (vt_veto),
        .rd_addr (bx_cnt),
        .rd_bit  (veto_now)
    );

    tdu_throttle_mon #(
        .NUM_CRATES (NUM_CRATES),
        .BX_W       (BX_W)
    ) u_thr (
        .clk       (clk),
        .rst_n     (rst_n),
        .thr_in    (throttle_in),
        .bx_now    (bx_cnt),
        .any_thr   (thr_any),
        .rpt_valid (thr_rpt_valid),
        .rpt_mask  (thr_rpt_mask),
        .rpt_bxid  (thr_rpt_bxid)
    );

    tdu_drain_fsm #(
        .GAP_W (GAP_W)
    ) u_drain (
        .clk      (clk),
        .rst_n    (rst_n),
        .nzs_take (nzs_take),
        .gap_cfg  (ho_gap),
        .draining (draining)
    );

    // per-crossing decision
    always_comb begin
        want     = llt_yes | cal_req;
        take     = want & ~veto_now & ~thr_any;
        nzs_take = take & nzs_req & ~draining;

        rec_now.valid  = 1'b1;
        rec_now.accept = take;
        rec_now.bxid   = bx_cnt;
        if (cal_req) begin
            rec_now.kind = KIND_CAL;
            rec_now.code = cal_code;
        end else if (llt_yes) begin
            rec_now.kind = KIND_PHYS;
            rec_now.code = '0;
        end else begin
            rec_now.kind = KIND_NONE;
            rec_now.code = '0;
        end
        rec_now.veto = veto_now;
        rec_now.ho   = veto_now | draining;
        rec_now.nzs  = nzs_take;
    end

    // dead-time accounting, veto takes precedence
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dead_thr_cnt  <= '0;
            dead_veto_cnt <= '0;
        end else if (want && veto_now) begin
            if (dead_veto_cnt != '1) begin
                dead_veto_cnt <= dead_veto_cnt + 1'b1;
            end
        end else if (want && thr_any) begin
            if (dead_thr_cnt != '1) begin
                dead_thr_cnt <= dead_thr_cnt + 1'b1;
            end
        end
    end

    AST_DEAD_THR_MONO: assert property (@(posedge clk) disable iff (!rst_n)
        dead_thr_cnt >= $past(dead_thr_cnt)); // R8
    AST_DEAD_VETO_MONO: assert property (@(posedge clk) disable iff (!rst_n)
        dead_veto_cnt >= $past(dead_veto_cnt)); // R8

    tdu_delay_line #(
        .DEPTH (LATENCY),
        .W     (REC_W)
    ) u_pipe (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (rec_now),
        .q     (rec_out_bits)
    );

    always_comb begin
        rec_out         = rec_t'(rec_out_bits);
        dec_valid       = rec_out.valid;
        dec_accept      = rec_out.accept;
        dec_bxid        = rec_out.bxid;
        dec_kind        = rec_out.kind;
        dec_cal_code    = rec_out.code;
        dec_veto        = rec_out.veto;
        dec_header_only = rec_out.ho;
        dec_nzs         = rec_out.nzs;
    end

    AST_ACCEPT_NOT_VETOED: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && dec_accept) |-> !dec_veto); // R6
    AST_CODE_ONLY_CAL: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && (dec_kind != KIND_CAL)) |-> (dec_cal_code == '0)); // R3
    AST_NZS_FULL_READ: assert property (@(posedge clk) disable iff (!rst_n)
        dec_nzs |-> (dec_accept && !dec_header_only)); // R7

endmodule

// File: tb/trig_decision_unit_bench.sv
`timescale 1ns/1ps
module trig_decision_unit_bench;
    localparam int NB = 3564;
    localparam int L  = 4;
    localparam int NV = 15;

    typedef struct packed {
        logic       llt;
        logic       cal;
        logic [3:0] code;
        logic [1:0] thr;
        logic       nzs;
        logic       e_acc;
        logic [1:0] e_kind;
        logic [3:0] e_code;
        logic       e_veto;
        logic       e_ho;
        logic       e_nzs;
    } vec_t;

    // table veto set at crossings 5, 9, 14; gap = 2
    localparam vec_t VEC [NV] = '{
        '{1'b0,1'b0,4'd0,2'b00,1'b0, 1'b0,2'd0,4'd0,1'b0,1'b0,1'b0}, // R3 none
        '{1'b1,1'b0,4'd0,2'b00,1'b0, 1'b1,2'd1,4'd0,1'b0,1'b0,1'b0}, // R3 llt
        '{1'b0,1'b1,4'd5,2'b00,1'b0, 1'b1,2'd2,4'd5,1'b0,1'b0,1'b0}, // R3 cal
        '{1'b1,1'b1,4'd3,2'b00,1'b0, 1'b1,2'd2,4'd3,1'b0,1'b0,1'b0}, // R3 override
        '{1'b1,1'b0,4'd0,2'b01,1'b0, 1'b0,2'd1,4'd0,1'b0,1'b0,1'b0}, // R4
        '{1'b1,1'b0,4'd0,2'b01,1'b0, 1'b0,2'd1,4'd0,1'b1,1'b1,1'b0}, // R6 veto+thr
        '{1'b0,1'b1,4'd1,2'b10,1'b0, 1'b0,2'd2,4'd1,1'b0,1'b0,1'b0}, // R4
        '{1'b1,1'b0,4'd0,2'b00,1'b1, 1'b1,2'd1,4'd0,1'b0,1'b0,1'b1}, // R7 nzs
        '{1'b1,1'b0,4'd0,2'b00,1'b0, 1'b1,2'd1,4'd0,1'b0,1'b1,1'b0}, // R7 drain
        '{1'b1,1'b0,4'd0,2'b00,1'b1, 1'b0,2'd1,4'd0,1'b1,1'b1,1'b0}, // R6 veto
        '{1'b1,1'b0,4'd0,2'b00,1'b1, 1'b1,2'd1,4'd0,1'b0,1'b0,1'b1}, // R7 nzs
        '{1'b1,1'b0,4'd0,2'b00,1'b1, 1'b1,2'd1,4'd0,1'b0,1'b1,1'b0}, // R7 ignored
        '{1'b0,1'b0,4'd0,2'b00,1'b0, 1'b0,2'd0,4'd0,1'b0,1'b1,1'b0}, // R7 drain
        '{1'b1,1'b0,4'd0,2'b00,1'b0, 1'b1,2'd1,4'd0,1'b0,1'b0,1'b0}, // R7 ended
        '{1'b0,1'b0,4'd0,2'b00,1'b0, 1'b0,2'd0,4'd0,1'b1,1'b1,1'b0}  // R6 no req
    };
    localparam string TAG [NV] = '{"R3","R3","R3","R3","R4","R6","R4","R7",
                                   "R7","R6","R7","R7","R7","R7","R6"};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        orbit_sync = 1'b0;
    logic        llt_yes = 1'b0;
    logic        cal_req = 1'b0;
    logic [3:0]  cal_code = '0;
    logic        nzs_req = 1'b0;
    logic [1:0]  throttle_in = '0;
    logic [3:0]  ho_gap = 4'd2;
    logic        vt_we = 1'b0;
    logic [11:0] vt_addr = '0;
    logic        vt_veto = 1'b0;
    logic        dec_valid, dec_accept, dec_veto, dec_header_only, dec_nzs;
    logic [11:0] dec_bxid;
    logic [1:0]  dec_kind;
    logic [3:0]  dec_cal_code;
    logic        thr_rpt_valid;
    logic [1:0]  thr_rpt_mask;
    logic [11:0] thr_rpt_bxid;
    logic [15:0] dead_thr_cnt, dead_veto_cnt;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    trig_decision_unit #(
        .NUM_BX(NB), .NUM_CRATES(2), .LATENCY(L), .CAL_W(4), .GAP_W(4), .CNT_W(16)
    ) u_trig_decision_unit (
        .clk(clk), .rst_n(rst_n), .orbit_sync(orbit_sync), .llt_yes(llt_yes),
        .cal_req(cal_req), .cal_code(cal_code), .nzs_req(nzs_req),
        .throttle_in(throttle_in), .ho_gap(ho_gap), .vt_we(vt_we),
        .vt_addr(vt_addr), .vt_veto(vt_veto), .dec_valid(dec_valid),
        .dec_accept(dec_accept), .dec_bxid(dec_bxid), .dec_kind(dec_kind),
        .dec_cal_code(dec_cal_code), .dec_veto(dec_veto),
        .dec_header_only(dec_header_only), .dec_nzs(dec_nzs),
        .thr_rpt_valid(thr_rpt_valid), .thr_rpt_mask(thr_rpt_mask),
        .thr_rpt_bxid(thr_rpt_bxid), .dead_thr_cnt(dead_thr_cnt),
        .dead_veto_cnt(dead_veto_cnt)
    );

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic drive(input logic l, input logic c, input logic [3:0] cd,
                         input logic [1:0] t, input logic n);
        llt_yes = l; cal_req = c; cal_code = cd; throttle_in = t; nzs_req = n;
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic idle();
        drive(1'b0, 1'b0, 4'd0, 2'b00, 1'b0);
    endtask

    task automatic align();
        idle();
        orbit_sync = 1'b1;
        step();
        orbit_sync = 1'b0;
    endtask

    task automatic write_veto(input logic [11:0] a, input logic v);
        vt_we = 1'b1; vt_addr = a; vt_veto = v;
        step();
        vt_we = 1'b0;
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            summary();
            $finish;
        end
    end

    initial begin
        step();
        step();
        // R1 reset state
        check("R1", "dec_valid in reset", 32'(dec_valid), 32'd0);
        check("R1", "report in reset", 32'(thr_rpt_valid), 32'd0);
        check("R1", "counters in reset", {dead_thr_cnt, dead_veto_cnt}, 32'd0);
        rst_n = 1'b1;

        write_veto(12'd5, 1'b1);
        write_veto(12'd9, 1'b1);
        write_veto(12'd14, 1'b1);
        align();

        // table walk: vector i is crossing ID i
        for (int i = 0; i < NV + L - 1; i++) begin
            if (i < NV) drive(VEC[i].llt, VEC[i].cal, VEC[i].code, VEC[i].thr, VEC[i].nzs);
            else idle();
            step();
            if (i >= L - 1) begin : chk
                int j;
                logic [31:0] act, exp;
                j = i - (L - 1);
                act = 32'({dec_valid, dec_accept, dec_bxid, dec_kind, dec_cal_code,
                           dec_veto, dec_header_only, dec_nzs});
                exp = 32'({1'b1, VEC[j].e_acc, 12'(j), VEC[j].e_kind, VEC[j].e_code,
                           VEC[j].e_veto, VEC[j].e_ho, VEC[j].e_nzs});
                check(TAG[j], $sformatf("vector %0d record", j), act, exp);
            end
        end

        // R8 counters: throttle losses at 4 and 6, veto losses at 5 and 9
        check("R8", "dead_thr_cnt", 32'(dead_thr_cnt), 32'd2);
        check("R8", "dead_veto_cnt", 32'(dead_veto_cnt), 32'd2);

        // R5 throttle reports
        align();
        idle(); step();
        step();
        drive(1'b0, 1'b0, 4'd0, 2'b01, 1'b0); step();
        check("R5", "first rise report", {thr_rpt_valid, 1'b0, thr_rpt_mask, thr_rpt_bxid},
              {1'b1, 1'b0, 2'b01, 12'd2});
        step();
        check("R5", "held bit silent", 32'(thr_rpt_valid), 32'd0);
        drive(1'b0, 1'b0, 4'd0, 2'b11, 1'b0); step();
        check("R5", "second crate rise", {thr_rpt_valid, 1'b0, thr_rpt_mask, thr_rpt_bxid},
              {1'b1, 1'b0, 2'b10, 12'd4});
        idle(); step();
        check("R5", "release silent", 32'(thr_rpt_valid), 32'd0);
        check("R8", "no request no count", {dead_thr_cnt, dead_veto_cnt}, {16'd2, 16'd2});

        // R2 orbit restart and wrap
        align();
        drive(1'b1, 1'b0, 4'd0, 2'b00, 1'b0); step();
        idle();
        repeat (L - 1) step();
        check("R2", "orbit restart id", {dec_valid, dec_accept, 8'd0, dec_bxid},
              {1'b1, 1'b1, 8'd0, 12'd0});
        repeat (NB - L - 1) step();
        drive(1'b1, 1'b0, 4'd0, 2'b00, 1'b0); step();
        drive(1'b1, 1'b0, 4'd0, 2'b00, 1'b0); step();
        idle();
        repeat (L - 2) step();
        check("R2", "last id before wrap", {dec_accept, 3'd0, dec_bxid}, {1'b1, 3'd0, 12'(NB - 1)});
        step();
        check("R2", "id after wrap", {dec_accept, 3'd0, dec_bxid}, {1'b1, 3'd0, 12'd0});

        // R7 zero gap opens no window
        ho_gap = 4'd0;
        align();
        drive(1'b1, 1'b0, 4'd0, 2'b00, 1'b1); step();
        drive(1'b1, 1'b0, 4'd0, 2'b00, 1'b0); step();
        idle();
        repeat (L - 2) step();
        check("R7", "gap0 nzs crossing", {dec_nzs, dec_header_only}, 32'b10);
        step();
        check("R7", "gap0 next crossing", {dec_accept, dec_header_only}, 32'b10);

        // R1 reset clears table and counters
        rst_n = 1'b0;
        step();
        check("R1", "counters cleared", {dead_thr_cnt, dead_veto_cnt}, 32'd0);
        check("R1", "dec_valid cleared", 32'(dec_valid), 32'd0);
        rst_n = 1'b1;
        repeat (5) step();
        drive(1'b1, 1'b0, 4'd0, 2'b00, 1'b0); step();
        idle();
        repeat (L - 1) step();
        check("R1", "table cleared at 5", {dec_accept, dec_veto, 2'b00, dec_bxid},
              {1'b1, 1'b0, 2'b00, 12'd5});

        done = 1'b1;
        summary();
        $finish;
    end

endmodule